// File: doc/BRIEF.md
# Serial Program/Verify Target Controller

This block is the device-side engine of a two-wire in-circuit programming port. An external programmer drives a slow serial clock and a shared data pin. The block samples both on a fast system clock through synchronizers and finds the serial clock edges in that domain. It takes in 6-bit commands and 16-cycle data frames, and it keeps a programming address counter. During a read frame it drives the data pin through an output enable. It reaches program, configuration and data storage through a simple single-port memory interface. The real cell erase and write time is replaced by a busy timer of fixed length.

The address space is split into two halves of equal size. The lower half is user program memory and the upper half is configuration memory. The counter wraps inside whichever half it points to. Once the counter is in configuration memory, only a new entry or a reset brings it back to user memory.

A frame has one start cycle, fourteen data cycles sent least significant bit first, and one stop cycle. Writes to the byte-wide data memory keep only the low eight data bits, but the whole frame must still be clocked.

Top module: `ser_prog_target`

## Requirements
- R1: While `prog_en` is low, and on system reset, the address counter is 0, `mem_sel` is 0 (user), `pdat_oe` is 0 and `busy` is 0. Raising `prog_en` starts the mode in that state.
- R2: A command is 6 serial clock cycles. One bit is taken on each falling edge of `pclk_in`, least significant bit first.
- R3: A load frame is 16 serial cycles. Falling edge 1 is the start bit, falling edges 2 to 15 carry data bits 0 to 13, and falling edge 16 is the stop bit. The word is kept for a later begin command.
- R4: In a read frame, `pdat_oe` rises after the 2nd rising edge of `pclk_in`. Rising edges 2 to 15 put data bits 0 to 13 on `pdat_out`. `pdat_oe` falls after the 16th rising edge. `pdat_oe` is never high outside a read frame.
- R5: Bits [5:4] of a command are ignored for these codes in bits [3:0]: 0000 load configuration, 0010 load program, 0011 load data memory, 0100 read program, 0101 read data memory, 0110 increment address.
- R6: The increment command adds one to the counter. In user memory, the counter goes from the top of the lower half back to 0.
- R7: Load configuration sets the counter to the base of the upper half (`mem_sel`=1). From there the counter goes from all-ones back to that base. Load and read program commands then target configuration memory (`mem_sel`=1) until R1 clears it.
- R8: Data memory (`mem_sel`=2) is addressed by the low `DMEM_AW` counter bits and stores only data bits [7:0], with the upper bits zero. A data memory read returns bits [7:0] with the upper bits zero, and returns all zeros while `code_protect` is high.
- R9: Command 001000 (erase then program) and command 011000 (program only) give one `mem_we` pulse, with `mem_erase` high only for the first, carrying the loaded word to `mem_addr`/`mem_sel`. They have no effect unless a load frame has completed since the last begin command or read command.
- R10: A begin command that writes, or a completed bulk erase pair, holds `busy` for exactly `BUSY_CYC` system cycles. Any command that finishes while `busy` is high is ignored.
- R11: Configuration offsets 8 to 15 (relative to the upper-half base) read as all ones.
- R12: Command 000001 followed directly by command 000111 pulses `mem_bulk` once. Command 000111 without 000001 just before it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_en | input | 1 | Programming mode entry; low holds the engine cleared |
| pclk_in | input | 1 | Serial programming clock (asynchronous) |
| pdat_in | input | 1 | Serial data pin input (asynchronous) |
| pdat_out | output | 1 | Serial data pin output value |
| pdat_oe | output | 1 | Serial data pin output enable |
| code_protect | input | 1 | Blanks data memory reads when high |
| busy | output | 1 | Modelled erase/write in progress |
| mem_addr | output | AW | Memory address (low bits only for data memory) |
| mem_sel | output | 2 | Target: 0 user, 1 configuration, 2 data memory |
| mem_rdata | input | DW | Read word from the selected memory |
| mem_wdata | output | DW | Word to be written |
| mem_we | output | 1 | One-cycle write strobe |
| mem_erase | output | 1 | Erase before write, valid with `mem_we` |
| mem_bulk | output | 1 | One-cycle bulk erase strobe |

## Verification
The bench builds the block with `AW`=6, `DMEM_AW`=4 and `BUSY_CYC`=300. Each address half is then only 32 words, so single-step increments reach both wrap points, and the configuration all-ones window at offsets 8 to 15 is reached in a few commands. The short busy window still leaves room to send a whole command while busy is high, so the ignore rule is exercised, and the bench measures the exact length of every busy period.

// File: rtl/sptc_pkg.sv
package sptc_pkg;
  localparam int CMD_W = 6;

  typedef enum logic [1:0] {
    SEL_USER = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_DATA = 2'd2
  } mem_sel_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_LOAD,
    PH_READ
  } phase_e;

  // operation field (command bits [3:0])
  localparam logic [3:0] OP_LD_CFG = 4'h0;
  localparam logic [3:0] OP_LD_PRG = 4'h2;
  localparam logic [3:0] OP_LD_DAT = 4'h3;
  localparam logic [3:0] OP_RD_PRG = 4'h4;
  localparam logic [3:0] OP_RD_DAT = 4'h5;
  localparam logic [3:0] OP_INC    = 4'h6;

  // fully decoded commands
  localparam logic [5:0] CMD_BEGIN_EP = 6'b001000;
  localparam logic [5:0] CMD_BEGIN_P  = 6'b011000;
  localparam logic [5:0] CMD_BULK1    = 6'b000001;
  localparam logic [5:0] CMD_BULK2    = 6'b000111;
endpackage

// File: rtl/sptc_sync.sv
module sptc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sptc_addr_ctr.sv
module sptc_addr_ctr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_cfg,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};

  // region bit is kept; offset wraps inside its half
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return {a[AW-1], a[AW-2:0] + (AW-1)'(1)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (clr)     addr <= '0;
    else if (set_cfg) addr <= CFG_BASE;
    else if (inc)     addr <= addr_step(addr);
  end
endmodule

// File: rtl/sptc_busy_timer.sv
module sptc_busy_timer #(
  parameter int CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ser_prog_target.sv
module ser_prog_target
  import sptc_pkg::*;
#(
  parameter int AW          = 14,
  parameter int DW          = 14,
  parameter int DMEM_AW     = 8,
  parameter int DMEM_DW     = 8,
  parameter int BUSY_CYC    = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic          pclk_in,
  input  logic          pdat_in,
  output logic          pdat_out,
  output logic          pdat_oe,
  input  logic          code_protect,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_sel,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_erase,
  output logic          mem_bulk
);
  localparam int FRAME_LEN = DW + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IW        = $clog2(DW);
  localparam logic [AW-2:0] HOLE_LO = (AW-1)'(8);
  localparam logic [AW-2:0] HOLE_HI = (AW-1)'(15);

  // ---------------- input synchronizers and edge events
  logic [1:0] s_q;
  logic       pclk_s, pdat_s, pclk_d, pe_rise, pe_fall, clr;

  sptc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({pdat_in, pclk_in}), .q (s_q)
  );
  assign pclk_s = s_q[0];
  assign pdat_s = s_q[1];
  assign clr    = !prog_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_d <= 1'b0;
    else        pclk_d <= pclk_s;
  end
  assign pe_rise = pclk_s & ~pclk_d;
  assign pe_fall = ~pclk_s & pclk_d;

  // ---------------- state
  phase_e          phase;
  mem_sel_e        sel_q;
  logic [CNT_W-1:0] fcnt, rcnt;
  logic [CMD_W-1:0] cmd_sh, cmd_nxt;
  logic [DW-1:0]    din_sh, dout_sh, wdata_q;
  logic             load_valid, bulk_armed;
  logic [AW-1:0]    addr_q;
  logic [IW-1:0]    fidx, ridx;

  // ---------------- decode (named events)
  logic [3:0] op4;
  logic ev_cmd_done, ev_cmd_take, ev_inc, ev_set_cfg, ev_begin, ev_bulk;
  logic is_begin_ep, is_begin_p, is_bulk1, is_bulk2, is_load, is_read;
  logic in_read;

  assign cmd_nxt     = {pdat_s, cmd_sh[CMD_W-1:1]};
  assign op4         = cmd_nxt[3:0];
  assign is_begin_ep = (cmd_nxt == CMD_BEGIN_EP);
  assign is_begin_p  = (cmd_nxt == CMD_BEGIN_P);
  assign is_bulk1    = (cmd_nxt == CMD_BULK1);
  assign is_bulk2    = (cmd_nxt == CMD_BULK2);
  assign is_load     = (op4 == OP_LD_CFG) || (op4 == OP_LD_PRG) || (op4 == OP_LD_DAT);
  assign is_read     = (op4 == OP_RD_PRG) || (op4 == OP_RD_DAT);

  assign ev_cmd_done = (phase == PH_CMD) && pe_fall && (fcnt == CNT_W'(CMD_W - 1));
  assign ev_cmd_take = ev_cmd_done && !busy;
  assign ev_inc      = ev_cmd_take && (op4 == OP_INC);
  assign ev_set_cfg  = ev_cmd_take && (op4 == OP_LD_CFG);
  assign ev_begin    = ev_cmd_take && (is_begin_ep || is_begin_p) && load_valid;
  assign ev_bulk     = ev_cmd_take && is_bulk2 && bulk_armed;
  assign in_read     = (phase == PH_READ);

  assign fidx = IW'(fcnt - 1'b1);
  assign ridx = IW'(rcnt - 1'b1);

  // ---------------- arithmetic helpers
  function automatic mem_sel_e prog_target(input logic [AW-1:0] a);
    return a[AW-1] ? SEL_CFG : SEL_USER;
  endfunction

  function automatic logic [DW-1:0] read_value(input mem_sel_e s, input logic [AW-1:0] a,
                                               input logic [DW-1:0] rd, input logic cp);
    logic [AW-2:0] off;
    off = a[AW-2:0];
    if (s == SEL_DATA) return cp ? '0 : {{(DW-DMEM_DW){1'b0}}, rd[DMEM_DW-1:0]};
    if (s == SEL_CFG && off >= HOLE_LO && off <= HOLE_HI) return '1;
    return rd;
  endfunction

  function automatic logic [DW-1:0] narrow_data(input logic [DW-1:0] w);
    return {{(DW-DMEM_DW){1'b0}}, w[DMEM_DW-1:0]};
  endfunction

  // ---------------- sub-blocks
  sptc_addr_ctr #(.AW(AW)) u_addr (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .set_cfg (ev_set_cfg), .inc (ev_inc), .addr (addr_q)
  );

  sptc_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .start (ev_begin || ev_bulk), .busy (busy)
  );

  // ---------------- frame engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;  sel_q <= SEL_USER;  fcnt <= '0;  rcnt <= '0;
      cmd_sh <= '0;  din_sh <= '0;  dout_sh <= '0;  wdata_q <= '0;
      load_valid <= 1'b0;  bulk_armed <= 1'b0;
      pdat_out <= 1'b0;  pdat_oe <= 1'b0;
      mem_we <= 1'b0;  mem_erase <= 1'b0;  mem_bulk <= 1'b0;
    end else if (clr) begin
      phase <= PH_CMD;  sel_q <= SEL_USER;  fcnt <= '0;  rcnt <= '0;
      cmd_sh <= '0;  din_sh <= '0;  dout_sh <= '0;  wdata_q <= '0;
      load_valid <= 1'b0;  bulk_armed <= 1'b0;
      pdat_out <= 1'b0;  pdat_oe <= 1'b0;
      mem_we <= 1'b0;  mem_erase <= 1'b0;  mem_bulk <= 1'b0;
    end else begin
      mem_we    <= ev_begin;
      mem_erase <= ev_begin && is_begin_ep;
      mem_bulk  <= ev_bulk;
      if (ev_begin) load_valid <= 1'b0;

      unique case (phase)
        PH_CMD: begin
          if (pe_fall) begin
            cmd_sh <= cmd_nxt;
            if (ev_cmd_done) begin
              fcnt <= '0;
              if (!busy) begin
                bulk_armed <= is_bulk1;
                if (is_load) begin
                  phase <= PH_LOAD;
                  if (op4 == OP_LD_DAT)      sel_q <= SEL_DATA;
                  else if (op4 == OP_LD_CFG) sel_q <= SEL_CFG;
                  else                       sel_q <= prog_target(addr_q);
                end else if (is_read) begin
                  phase      <= PH_READ;
                  rcnt       <= '0;
                  load_valid <= 1'b0;
                  sel_q      <= (op4 == OP_RD_DAT) ? SEL_DATA : prog_target(addr_q);
                end
              end
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end

        PH_LOAD: begin
          if (pe_fall) begin
            if (fcnt >= CNT_W'(1) && fcnt <= CNT_W'(DW)) din_sh[fidx] <= pdat_s;
            if (fcnt == CNT_W'(FRAME_LEN - 1)) begin
              phase      <= PH_CMD;
              fcnt       <= '0;
              wdata_q    <= (sel_q == SEL_DATA) ? narrow_data(din_sh) : din_sh;
              load_valid <= 1'b1;
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end

        PH_READ: begin
          if (pe_rise) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt == '0) begin
              dout_sh <= read_value(sel_q, addr_q, mem_rdata, code_protect);
            end else if (rcnt <= CNT_W'(DW)) begin
              pdat_oe  <= 1'b1;
              pdat_out <= dout_sh[ridx];
            end else begin
              pdat_oe  <= 1'b0;
              pdat_out <= 1'b0;
            end
          end
          if (pe_fall) begin
            if (fcnt == CNT_W'(FRAME_LEN - 1)) begin
              phase   <= PH_CMD;
              fcnt    <= '0;
              pdat_oe <= 1'b0;
            end else begin
              fcnt <= fcnt + 1'b1;
            end
          end
        end

        default: phase <= PH_CMD;
      endcase
    end
  end

  // ---------------- memory port
  assign mem_sel   = sel_q;
  assign mem_addr  = (sel_q == SEL_DATA) ? {{(AW-DMEM_AW){1'b0}}, addr_q[DMEM_AW-1:0]} : addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/sptc_checker.sv
module sptc_checker #(
  parameter int AW = 14,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_en,
  input logic [AW-1:0] addr,
  input logic          ev_inc,
  input logic          mem_we,
  input logic          busy,
  input logic          pdat_oe,
  input logic          in_read,
  input logic [CW-1:0] rcnt
);
  localparam logic [AW-1:0] USER_TOP = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};

  AST_USER_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    (ev_inc && addr == USER_TOP) |=> (addr == '0));                          // R6
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    addr[AW-1] |=> addr[AW-1]);                                             // R7
  AST_CFG_WRAP: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    (ev_inc && addr == '1) |=> (addr == CFG_BASE));                          // R7
  AST_WE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    mem_we |-> !$past(busy));                                               // R10
  AST_WE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    mem_we |-> busy);                                                       // R10
  AST_OE_SECOND_RISE: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    $rose(pdat_oe) |-> (rcnt == CW'(2)));                                   // R4
  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
    pdat_oe |-> in_read);                                                   // R4
endmodule

bind ser_prog_target sptc_checker #(.AW(AW), .CW(CNT_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .prog_en (prog_en), .addr (addr_q),
  .ev_inc (ev_inc), .mem_we (mem_we), .busy (busy), .pdat_oe (pdat_oe),
  .in_read (in_read), .rcnt (rcnt)
);

// File: tb/ser_prog_target_bench.sv
`timescale 1ns/1ps
module ser_prog_target_bench;
  localparam int AW = 6, DW = 14, DMEM_AW = 4, BUSY = 300;
  localparam int H = 6, GAP = 24;

  logic clk = 0, rst_n = 0, prog_en = 0, pclk_in = 0, pdat_in = 0, code_protect = 0;
  logic pdat_out, pdat_oe, busy, mem_we, mem_erase, mem_bulk;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_sel;
  logic [DW-1:0] mem_rdata, mem_wdata;

  always #4 clk = ~clk;

  ser_prog_target #(.AW(AW), .DW(DW), .DMEM_AW(DMEM_AW), .BUSY_CYC(BUSY)) u_ser_prog_target (
    .clk, .rst_n, .prog_en, .pclk_in, .pdat_in, .pdat_out, .pdat_oe, .code_protect,
    .busy, .mem_addr, .mem_sel, .mem_rdata, .mem_wdata, .mem_we, .mem_erase, .mem_bulk
  );

  int n_vec = 0, n_err = 0, n_bulk = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model
  logic [DW-1:0] m_user [64];
  logic [DW-1:0] m_cfg  [64];
  logic [DW-1:0] m_dat  [64];
  initial for (int i = 0; i < 64; i++) begin
    m_user[i] = 14'h0100 + 14'(i);
    m_cfg[i]  = 14'h0200 + 14'(i);
    m_dat[i]  = 14'h3F50 + 14'(i);
  end
  always_comb begin
    case (mem_sel)
      2'd0:    mem_rdata = m_user[mem_addr];
      2'd1:    mem_rdata = m_cfg[mem_addr];
      default: mem_rdata = m_dat[mem_addr];
    endcase
  end
  always @(posedge clk) if (mem_we) begin
    case (mem_sel)
      2'd0:    m_user[mem_addr] <= mem_wdata;
      2'd1:    m_cfg[mem_addr]  <= mem_wdata;
      default: m_dat[mem_addr]  <= mem_wdata;
    endcase
  end

  // ---------------- scoreboard queues
  typedef struct packed {
    logic [AW-1:0] a;
    logic [1:0]    s;
    logic [DW-1:0] d;
    logic          e;
  } wr_t;
  wr_t           exp_wr[$];
  logic [DW-1:0] exp_rd[$];

  // write monitor (R9)
  always @(negedge clk) if (mem_we) begin
    wr_t w;
    if (exp_wr.size() == 0) begin
      n_vec++; n_err++;
      $display("FAIL R9 unexpected write act=%0h exp=none", mem_wdata);
    end else begin
      w = exp_wr.pop_front();
      check("R9 write addr", 32'(mem_addr), 32'(w.a));
      check("R9 write sel", 32'(mem_sel), 32'(w.s));
      check("R9 write data", 32'(mem_wdata), 32'(w.d));
      check("R9 erase flag", 32'(mem_erase), 32'(w.e));
    end
  end

  // read monitor (R4): one bit per falling edge while the pin is driven
  logic [DW-1:0] rd_word = '0;
  int nbits = 0;
  always @(negedge pclk_in) if (pdat_oe) begin
    if (nbits < DW) rd_word[nbits] = pdat_out;
    nbits++;
  end
  always @(negedge pdat_oe) if (prog_en) begin
    check("R4 bits driven", 32'(nbits), 32'(DW));
    if (exp_rd.size() == 0) begin
      n_vec++; n_err++;
      $display("FAIL R4 unexpected read act=%0h exp=none", rd_word);
    end else begin
      check("R4 read word", 32'(rd_word), 32'(exp_rd.pop_front()));
    end
    nbits = 0;
    rd_word = '0;
  end

  // busy length monitor (R10) and bulk pulse counter (R12)
  int bcnt = 0;
  always @(negedge clk) begin
    if (!prog_en) bcnt = 0;
    else if (busy) bcnt++;
    else if (bcnt != 0) begin
      check("R10 busy length", 32'(bcnt), 32'(BUSY));
      bcnt = 0;
    end
    if (mem_bulk) n_bulk++;
  end

  // ---------------- driver tasks
  task automatic send_bit(input logic b);
    @(negedge clk); pdat_in = b; pclk_in = 1'b1;
    repeat (H) @(negedge clk);
    pclk_in = 1'b0;
    repeat (H) @(negedge clk);
  endtask
  task automatic cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) send_bit(c[i]);
    repeat (GAP) @(negedge clk);
  endtask
  task automatic frame(input logic [DW-1:0] d);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    send_bit(1'b0);
    repeat (GAP) @(negedge clk);
  endtask
  task automatic rframe();
    for (int i = 0; i < DW + 2; i++) send_bit(1'b0);
    repeat (GAP) @(negedge clk);
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  // ---------------- stimulus
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    prog_en = 1;
    repeat (5) @(negedge clk);
    check("R1 reset addr", 32'(mem_addr), 0);
    check("R1 reset oe", 32'(pdat_oe), 0);
    check("R1 reset busy", 32'(busy), 0);

    // R3/R5/R9: load program (upper bits 11), erase+program
    cmd(6'b110010); frame(14'h1234);
    exp_wr.push_back('{a: 6'd0, s: 2'd0, d: 14'h1234, e: 1'b1});
    cmd(6'b001000); wait_idle();

    // R4: read back
    exp_rd.push_back(14'h1234);
    cmd(6'b000100); rframe();

    // R6/R5: increments, upper bits 01 ignored
    cmd(6'b000110);
    check("R6 increment", 32'(mem_addr), 1);
    cmd(6'b010110);
    check("R5 upper bits ignored", 32'(mem_addr), 2);

    // R9: begin with no pending load
    cmd(6'b001000);
    repeat (4) @(negedge clk);
    check("R9 begin without load stays idle", 32'(busy), 0);

    // R8: data memory
    cmd(6'b000011); frame(14'h3FA5);
    check("R8 data sel", 32'(mem_sel), 2);
    exp_wr.push_back('{a: 6'd2, s: 2'd2, d: 14'h00A5, e: 1'b0});
    cmd(6'b011000); wait_idle();
    exp_rd.push_back(14'h00A5);
    cmd(6'b000101); rframe();
    code_protect = 1;
    exp_rd.push_back(14'h0000);
    cmd(6'b000101); rframe();
    code_protect = 0;

    // R6: user wrap
    cmd(6'b000010); frame(14'h0001);
    check("R6 user sel", 32'(mem_sel), 0);
    for (int i = 0; i < 29; i++) cmd(6'b000110);
    check("R6 user top", 32'(mem_addr), 31);
    cmd(6'b000110);
    check("R6 user wrap", 32'(mem_addr), 0);

    // R7: configuration region
    cmd(6'b000000); frame(14'h0ABC);
    check("R7 load cfg addr", 32'(mem_addr), 32);
    exp_wr.push_back('{a: 6'd32, s: 2'd1, d: 14'h0ABC, e: 1'b1});
    cmd(6'b001000); wait_idle();
    exp_rd.push_back(14'h0ABC);
    cmd(6'b000100); rframe();
    for (int i = 0; i < 8; i++) cmd(6'b000110);
    check("R11 hole addr", 32'(mem_addr), 40);
    exp_rd.push_back(14'h3FFF);          // R11 all ones
    cmd(6'b000100); rframe();
    for (int i = 0; i < 23; i++) cmd(6'b000110);
    check("R7 cfg top", 32'(mem_addr), 63);
    cmd(6'b000110);
    check("R7 cfg wrap", 32'(mem_addr), 32);
    cmd(6'b000010); frame(14'h1555);
    check("R7 sticky addr", 32'(mem_addr), 32);
    check("R7 sticky sel", 32'(mem_sel), 1);

    // R10: command during busy is ignored
    exp_wr.push_back('{a: 6'd32, s: 2'd1, d: 14'h1555, e: 1'b0});
    cmd(6'b011000);
    check("R10 busy after begin", 32'(busy), 1);
    cmd(6'b000110);
    wait_idle();
    check("R10 ignored increment", 32'(mem_addr), 32);

    // R12: bulk erase pair
    cmd(6'b000111);
    check("R12 lone setup2 pulse", 32'(n_bulk), 0);
    check("R12 lone setup2 busy", 32'(busy), 0);
    cmd(6'b000001); cmd(6'b000111);
    check("R12 bulk pulse", 32'(n_bulk), 1);
    check("R12 bulk busy", 32'(busy), 1);
    wait_idle();

    // R1: re-entry returns to user space; R2 LSb-first decode
    prog_en = 0;
    repeat (4) @(negedge clk);
    prog_en = 1;
    repeat (4) @(negedge clk);
    check("R1 entry addr", 32'(mem_addr), 0);
    check("R1 entry sel", 32'(mem_sel), 0);
    cmd(6'b000110);
    check("R2 lsb-first increment", 32'(mem_addr), 1);

    repeat (20) @(negedge clk);
    check("R9 pending writes", 32'(exp_wr.size()), 0);
    check("R4 pending reads", 32'(exp_rd.size()), 0);
    finish_run();
  end
endmodule